// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

A bank of 32-bit system-control words reached through a simple request bus: one request strobe, a write-enable, a byte address and write data. Accesses are word-sized and word-aligned. Any other access is refused and flagged as an error. Writes are refused until software writes a magic unlock value to the key word at index 0. Writing any other value to the key word locks the bank again.

Several control words collect bits. A write ORs data into the word, and the word one index above acts as a clear alias that removes bits. Two strap words can be frozen by a protect word two indices above them. Identity words and the random-data word reject writes. PLL status words always report lock on read. Each read of the random-data word first steps a 32-bit LFSR and returns the new value.

Reset defaults are computed from a table in the package. The two strap words, the board revision word and the key word take their reset values from input ports. Read data and the two error flags are registered and appear in the cycle after the request.

Top module: `sysctl_regbank`

## Requirements
- R1: The word index is `addr_i >> 2`. A request with `addr_i[1:0] != 0` is refused: a read returns 0, a write changes nothing, and `err_o` pulses.
- R2: A write to word 0 stores 1 when the data equals `UNLOCK_KEY`, and stores 0 for any other value. This write is accepted even while the bank is locked.
- R3: While word 0 holds 0, a write to any index from 1 upward changes nothing and pulses `lock_err_o`. `err_o` stays low for that write. Reads stay allowed.
- R4: A write to a collecting word ORs the data into it. The collecting words are reset control (word 4), clock gate (word 6), strap A (word 8) and strap B (word 12).
- R5: A write to the clear alias one index above a collecting word (words 5, 7, 9, 13) clears the bits of that word where the data has a 1. The alias has no storage and reads as 0.
- R6: A write to strap A or strap B is ignored without error while its protect word (word 10 or 14, two above) is nonzero. The strap clear alias still acts while the protect word is nonzero.
- R7: A write to revision A (word 1), revision B (word 2), chip identity (word 3) or the random-data word (word 20) is dropped and pulses `err_o`.
- R8: A read of a PLL status word (words 16, 17, 18) returns the stored value with bit 31 set to 1.
- R9: Each read of word 20 steps the LFSR once and returns the new state. The LFSR starts from `RNG_SEED`. One step is: shift right by one, then XOR with 0x80200003 if the bit shifted out was 1. The value of the RNG control word (word 21) has no effect on this.
- R10: A request to an index at or above `NUM_WORDS` (32) reads 0, leaves all words unchanged and pulses `err_o`.
- R11: After reset the words hold these values:
  - word 1 = 0x05020103
  - word 3 = 0x7E57C0DE
  - word 4 = 0xF0C30000
  - word 6 = 0x00007F8A
  - words 16, 17, 18 = 0x40, 0x41, 0x42
  - word 21 = 0x0E
  - words 8, 12, 2 and 0 take `strap_a_rst_i`, `strap_b_rst_i`, `rev_b_rst_i` and `key_rst_i`
  - all other words = 0
- R12: `rdata_o`, `err_o` and `lock_err_o` change at the clock edge that accepts the request. `rdata_o` changes only on reads. The two flags are high for one cycle.
- R13: A write to any other word inside the bank, while unlocked, stores the full data word, and a later read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (8) | Byte address |
| wdata_i | input | 32 | Write data |
| strap_a_rst_i | input | 32 | Reset value of strap A |
| strap_b_rst_i | input | 32 | Reset value of strap B |
| rev_b_rst_i | input | 32 | Reset value of revision B |
| key_rst_i | input | 32 | Reset value of the key word |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse: refused access (misaligned, out of range, read-only) |
| lock_err_o | output | 1 | One-cycle pulse: write refused because the bank is locked |

## Verification
The hardest state to reach is a strap word that is frozen while its clear alias still acts. Reaching it takes the whole chain: unlock, set bits on the strap, write a nonzero protect word, and only then attempt a set and a clear. The bench follows that chain in one task and reads the strap back after each step. That shows a refused set that is silent, with no error pulse, next to a clear that is accepted. The bench also checks that locking is restored by a wrong key. It then confirms that the word it tried to overwrite still holds its earlier value.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DW = 32;

  // word map: key at 0, clear alias at +1, protect word at +2 of a strap
  localparam int W_KEY    = 0;
  localparam int W_REVA   = 1;
  localparam int W_REVB   = 2;
  localparam int W_CHIPID = 3;
  localparam int W_RST    = 4;
  localparam int W_CLKG   = 6;
  localparam int W_STRAPA = 8;
  localparam int W_STRAPB = 12;
  localparam int W_PLL0   = 16;
  localparam int N_PLL    = 3;
  localparam int W_RNG    = 20;
  localparam int W_RNGCTL = 21;

  localparam logic [DW-1:0] REV_A_VAL   = 32'h0502_0103;
  localparam logic [DW-1:0] CHIP_ID_VAL = 32'h7E57_C0DE;
  localparam logic [DW-1:0] LFSR_MASK   = 32'h8020_0003;

  typedef enum logic [3:0] {
    K_PLAIN, K_KEY, K_RO, K_SET, K_CLR, K_STRAP, K_STRAP_CLR, K_PLL, K_RNG
  } kind_e;

  function automatic kind_e kind_of(int i);
    kind_e k;
    k = K_PLAIN;
    if (i == W_KEY) k = K_KEY;
    else if (i == W_REVA || i == W_REVB || i == W_CHIPID) k = K_RO;
    else if (i == W_RST || i == W_CLKG) k = K_SET;
    else if (i == W_RST + 1 || i == W_CLKG + 1) k = K_CLR;
    else if (i == W_STRAPA || i == W_STRAPB) k = K_STRAP;
    else if (i == W_STRAPA + 1 || i == W_STRAPB + 1) k = K_STRAP_CLR;
    else if (i >= W_PLL0 && i < W_PLL0 + N_PLL) k = K_PLL;
    else if (i == W_RNG) k = K_RNG;
    return k;
  endfunction

  function automatic logic [DW-1:0] reset_value(int i);
    logic [DW-1:0] v;
    v = '0;
    if (i == W_REVA) v = REV_A_VAL;
    else if (i == W_CHIPID) v = CHIP_ID_VAL;
    else if (i == W_RST) v = 32'hF0C3_0000;
    else if (i == W_CLKG) v = 32'h0000_7F8A;
    else if (i >= W_PLL0 && i < W_PLL0 + N_PLL) v = 32'h40 + DW'(i - W_PLL0);
    else if (i == W_RNGCTL) v = 32'h0000_000E;
    return v;
  endfunction
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 32,
  parameter int WIDX_W    = 5
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              unlocked_i,
  input  logic              prot_nz_i,
  output logic [WIDX_W-1:0] widx_o,
  output logic [WIDX_W-1:0] tgt_idx_o,
  output logic [WIDX_W-1:0] prot_idx_o,
  output kind_e             kind_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              err_o,
  output logic              lock_err_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             wr_req;

  assign idx        = addr_i[ADDR_W-1:2];
  assign in_range   = (addr_i[1:0] == 2'b00) &&
                      ({1'b0, idx} < (IDX_W+1)'(NUM_WORDS));
  assign widx_o     = idx[WIDX_W-1:0];
  assign tgt_idx_o  = widx_o - WIDX_W'(1);
  assign prot_idx_o = widx_o + WIDX_W'(2);
  assign kind_o     = kind_of(int'(widx_o));
  assign rd_o       = req_i && !we_i && in_range;
  assign wr_req     = req_i && we_i && in_range;

  always_comb begin
    wr_o       = 1'b0;
    err_o      = req_i && !in_range;
    lock_err_o = 1'b0;
    if (wr_req) begin
      if (!unlocked_i && kind_o != K_KEY) lock_err_o = 1'b1;
      else if (kind_o == K_RO || kind_o == K_RNG) err_o = 1'b1;
      else if (kind_o == K_STRAP && prot_nz_i) wr_o = 1'b0;
      else wr_o = 1'b1;
    end
  end

  always_comb begin
    assert_one_flag_R3: assert (!(err_o && lock_err_o));
  end
endmodule

// File: rtl/regbank_rng.sv
module regbank_rng
  import regbank_pkg::*;
#(
  parameter logic [DW-1:0] SEED = 32'hACE1_2468
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [DW-1:0] next_o
);
  logic [DW-1:0] state_q;

  assign next_o = state_q[0] ? ((state_q >> 1) ^ LFSR_MASK) : (state_q >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= next_o;
  end

  assert_rng_steps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> state_q != $past(state_q));
  assert_rng_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
  import regbank_pkg::*;
(
  input  logic          hit_i,
  input  kind_e         kind_i,
  input  logic [DW-1:0] stored_i,
  input  logic [DW-1:0] rng_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      unique case (kind_i)
        K_PLL:               rdata_o = stored_i | {1'b1, {(DW-1){1'b0}}};
        K_RNG:               rdata_o = rng_i;
        K_CLR, K_STRAP_CLR:  rdata_o = '0;
        default:             rdata_o = stored_i;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import regbank_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter int              NUM_WORDS  = 32,
  parameter logic [DW-1:0]   UNLOCK_KEY = 32'hC0DE_5A17,
  parameter logic [DW-1:0]   RNG_SEED   = 32'hACE1_2468
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     strap_a_rst_i,
  input  logic [DW-1:0]     strap_b_rst_i,
  input  logic [DW-1:0]     rev_b_rst_i,
  input  logic [DW-1:0]     key_rst_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic              lock_err_o
);
  localparam int WIDX_W = $clog2(NUM_WORDS);

  logic [DW-1:0]     regs_q [NUM_WORDS];
  logic [WIDX_W-1:0] widx, tgt_idx, prot_idx;
  kind_e             kind;
  logic              rd, wr, err_c, lock_c, unlocked, prot_nz;
  logic [DW-1:0]     rng_next, rd_val;

  assign unlocked = regs_q[W_KEY] != '0;
  assign prot_nz  = regs_q[prot_idx] != '0;

  regbank_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .unlocked_i(unlocked), .prot_nz_i(prot_nz),
    .widx_o(widx), .tgt_idx_o(tgt_idx), .prot_idx_o(prot_idx),
    .kind_o(kind), .rd_o(rd), .wr_o(wr), .err_o(err_c), .lock_err_o(lock_c)
  );

  regbank_rng #(.SEED(RNG_SEED)) u_rng (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .adv_i(rd && kind == K_RNG), .next_o(rng_next)
  );

  regbank_rdmux u_rdmux (
    .hit_i(rd), .kind_i(kind), .stored_i(regs_q[widx]),
    .rng_i(rng_next), .rdata_o(rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) regs_q[i] <= reset_value(i);
      regs_q[W_STRAPA] <= strap_a_rst_i;
      regs_q[W_STRAPB] <= strap_b_rst_i;
      regs_q[W_REVB]   <= rev_b_rst_i;
      regs_q[W_KEY]    <= key_rst_i;
    end else if (wr) begin
      unique case (kind)
        K_KEY:              regs_q[widx]    <= (wdata_i == UNLOCK_KEY) ? DW'(1) : '0;
        K_SET, K_STRAP:     regs_q[widx]    <= regs_q[widx] | wdata_i;
        K_CLR, K_STRAP_CLR: regs_q[tgt_idx] <= regs_q[tgt_idx] & ~wdata_i;
        default:            regs_q[widx]    <= wdata_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      err_o      <= 1'b0;
      lock_err_o <= 1'b0;
    end else begin
      err_o      <= err_c;
      lock_err_o <= lock_c;
      if (req_i && !we_i) rdata_o <= rd_val;
    end
  end

  assert_unlock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == '0 && wdata_i == UNLOCK_KEY) |=> regs_q[W_KEY] == DW'(1));
  assert_locked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && regs_q[W_KEY] == '0 && addr_i[ADDR_W-1:2] != '0 && addr_i[1:0] == 2'b00)
    |=> $stable(regs_q[W_RST]) && $stable(regs_q[W_STRAPA]));
  assert_set_or_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && regs_q[W_KEY] != '0 && addr_i == ADDR_W'(W_RST * 4))
    |=> (regs_q[W_RST] & $past(wdata_i)) == $past(wdata_i));
  assert_pll_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(W_PLL0 * 4)) |=> rdata_o[DW-1]);
  assert_oor_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[1:0] == 2'b00 &&
     {1'b0, addr_i[ADDR_W-1:2]} >= (ADDR_W-1)'(NUM_WORDS)) |=> (rdata_o == '0 && err_o));
  assert_misaligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |=> err_o && !lock_err_o);
endmodule

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY  = 32'hC0DE_5A17;
  localparam logic [31:0] SEED = 32'hACE1_2468;
  localparam logic [31:0] SA   = 32'h0000_00F0;
  localparam logic [31:0] SB   = 32'h1234_0000;
  localparam logic [31:0] RB   = 32'h0500_0303;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err, lock_err;
  int   nchk = 0, nfail = 0;
  logic [31:0] r_rd;
  logic r_err, r_lock;
  logic [31:0] lfsr = SEED;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regbank dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .strap_a_rst_i(SA), .strap_b_rst_i(SB),
    .rev_b_rst_i(RB), .key_rst_i(32'h0),
    .rdata_o(rdata), .err_o(err), .lock_err_o(lock_err)
  );

  function automatic logic [31:0] step(logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic acc(logic w, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    r_rd = rdata; r_err = err; r_lock = lock_err;
    req = 0; we = 0;
  endtask

  task automatic t_reset;
    acc(0, 8'h00, 0); chk("R11 key", r_rd, 0);
    acc(0, 8'h04, 0); chk("R11 revA", r_rd, 32'h0502_0103);
    acc(0, 8'h08, 0); chk("R11 revB", r_rd, RB);
    acc(0, 8'h0C, 0); chk("R11 chip", r_rd, 32'h7E57_C0DE);
    acc(0, 8'h10, 0); chk("R11 rst", r_rd, 32'hF0C3_0000);
    acc(0, 8'h18, 0); chk("R11 clkg", r_rd, 32'h0000_7F8A);
    acc(0, 8'h20, 0); chk("R11 strapA", r_rd, SA);
    acc(0, 8'h30, 0); chk("R11 strapB", r_rd, SB);
    acc(0, 8'h54, 0); chk("R11 rngctl", r_rd, 32'h0E);
    chk("R12 err idle", {31'b0, r_err}, 0);
  endtask

  task automatic t_locked;
    acc(1, 8'h60, 32'h11); chk("R3 lock flag", {31'b0, r_lock}, 1);
    chk("R3 no err", {31'b0, r_err}, 0);
    acc(0, 8'h60, 0); chk("R3 ignored", r_rd, 0);
    chk("R12 flag pulse", {31'b0, r_lock}, 0);
    acc(1, 8'h10, 32'hF); acc(0, 8'h10, 0); chk("R3 set ignored", r_rd, 32'hF0C3_0000);
  endtask

  task automatic t_unlock;
    acc(1, 8'h00, KEY); chk("R2 no lock flag", {31'b0, r_lock}, 0);
    acc(0, 8'h00, 0); chk("R2 unlocked", r_rd, 1);
    acc(1, 8'h60, 32'hA5A5_5A5A); acc(0, 8'h60, 0); chk("R13 plain", r_rd, 32'hA5A5_5A5A);
  endtask

  task automatic t_setclr;
    acc(1, 8'h10, 32'hF); acc(0, 8'h10, 0); chk("R4 set", r_rd, 32'hF0C3_000F);
    acc(1, 8'h14, 32'hF000_0001); acc(0, 8'h10, 0); chk("R5 clear", r_rd, 32'h00C3_000E);
    acc(0, 8'h14, 0); chk("R5 alias reads 0", r_rd, 0);
    acc(1, 8'h18, 32'h0001_0000); acc(0, 8'h18, 0); chk("R4 clkg set", r_rd, 32'h0001_7F8A);
  endtask

  task automatic t_strap;
    acc(1, 8'h20, 32'h0F00); acc(0, 8'h20, 0); chk("R4 strapA set", r_rd, 32'h0FF0);
    acc(1, 8'h28, 32'h1);
    acc(1, 8'h20, 32'hF000); chk("R6 frozen no err", {31'b0, r_err}, 0);
    acc(0, 8'h20, 0); chk("R6 frozen", r_rd, 32'h0FF0);
    acc(1, 8'h24, 32'h00F0); acc(0, 8'h20, 0); chk("R6 clear under protect", r_rd, 32'h0F00);
    acc(1, 8'h30, 32'h1); acc(0, 8'h30, 0); chk("R6 strapB free", r_rd, 32'h1234_0001);
  endtask

  task automatic t_readonly;
    acc(1, 8'h0C, 0); chk("R7 chip err", {31'b0, r_err}, 1);
    acc(0, 8'h0C, 0); chk("R7 chip kept", r_rd, 32'h7E57_C0DE);
    acc(1, 8'h08, 0); chk("R7 revB err", {31'b0, r_err}, 1);
    acc(0, 8'h08, 0); chk("R7 revB kept", r_rd, RB);
  endtask

  task automatic t_pll;
    acc(0, 8'h40, 0); chk("R8 pll0", r_rd, 32'h8000_0040);
    acc(0, 8'h48, 0); chk("R8 pll2", r_rd, 32'h8000_0042);
    acc(1, 8'h44, 32'h1234); acc(0, 8'h44, 0); chk("R8 pll1", r_rd, 32'h8000_1234);
  endtask

  task automatic t_rng;
    lfsr = step(lfsr); acc(0, 8'h50, 0); chk("R9 rng 1", r_rd, lfsr);
    lfsr = step(lfsr); acc(0, 8'h50, 0); chk("R9 rng 2", r_rd, lfsr);
    acc(1, 8'h54, 0);
    lfsr = step(lfsr); acc(0, 8'h50, 0); chk("R9 rng ctl off", r_rd, lfsr);
    acc(1, 8'h50, 32'hFFFF_FFFF); chk("R7 rng write err", {31'b0, r_err}, 1);
    lfsr = step(lfsr); acc(0, 8'h50, 0); chk("R9 write no step", r_rd, lfsr);
  endtask

  task automatic t_range;
    acc(0, 8'h80, 0); chk("R10 oor read", r_rd, 0); chk("R10 oor err", {31'b0, r_err}, 1);
    acc(1, 8'hFC, 32'h1); chk("R10 oor write err", {31'b0, r_err}, 1);
    acc(0, 8'h62, 0); chk("R1 misaligned read", r_rd, 0); chk("R1 misaligned err", {31'b0, r_err}, 1);
    acc(1, 8'h61, 32'hFFFF_FFFF); acc(0, 8'h60, 0); chk("R1 misaligned write", r_rd, 32'hA5A5_5A5A);
  endtask

  task automatic t_relock;
    acc(1, 8'h00, 32'h1234); acc(0, 8'h00, 0); chk("R2 relock", r_rd, 0);
    acc(1, 8'h60, 0); chk("R3 relocked flag", {31'b0, r_lock}, 1);
    acc(0, 8'h60, 0); chk("R3 relocked kept", r_rd, 32'hA5A5_5A5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_locked; t_unlock; t_setclr; t_strap;
    t_readonly; t_pll; t_rng; t_range; t_relock;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule